// File: doc/BRIEF.md
# UART Wake Handshake Responder

This block runs the answering side of a two-wire ready handshake that lets two chips sleep between UART exchanges. It drives its own ready line (`srdy`) and watches the peer's request line (`mrdyAsync`). The peer is the side that starts and ends each session. Two local flags come in: one says transmit data is waiting, and one says the UART is still moving bits. Two indications go out: a transmit grant that the local UART driver waits for, and a sleep permission that the power logic may act on.

A fresh rising request from the peer makes the block raise `srdy` at once. When the local side has data to send, the block raises `srdy` on its own and holds the grant low until the peer answers. The block drops `srdy` only when the peer has let go, the UART is idle and nothing is waiting to be sent.

If data stays pending while the peer stays quiet, the block drops `srdy` for a short gap and then raises it again. This gives the peer a new rising edge to answer, which breaks the deadlock.

Top module: `uart_wake_slave`

## Requirements
- R1: A rising level on `mrdyAsync` passes through two synchronizing flops. While `srdy` is low, `srdy` goes high on the third rising clock edge after the input changes.
- R2: When `dataPending` is high and `srdy` is low, `srdy` goes high on the next clock edge. `txGrant` stays low until the synchronized request is also high.
- R3: With `srdy` high, `srdy` falls on the next edge after a cycle in which the synchronized request is low, `uartBusy` is low and `dataPending` is low.
- R4: `sleepOk` is high only while `srdy` is low (and not in a deadlock gap), the synchronized request is low, `uartBusy` is low and `dataPending` is low.
- R5: If `srdy` is high while `dataPending` is high and the synchronized request is low for STALL_CYCLES consecutive clocks (default 16), `srdy` is driven low.
- R6: After such a deadlock drop, `srdy` stays low for exactly GAP_CYCLES clocks (default 4) and then rises again. During that time it ignores requests and `sleepOk` stays low.
- R7: `txGrant` is high exactly while `srdy` is high and the synchronized request is high. This shows as a two-clock lag behind `mrdyAsync`.
- R8: A synchronous reset (`rst` high) clears `srdy`, `txGrant`, the synchronizer and both timers. With idle inputs after reset, `sleepOk` is high.
- R9: While `uartBusy` is high, `srdy` stays high even when the request is low and no data is pending, and `sleepOk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mrdyAsync | input | 1 | Peer request line, asynchronous |
| dataPending | input | 1 | Local transmit data is waiting |
| uartBusy | input | 1 | Local UART is still transferring |
| srdy | output | 1 | Ready line driven to the peer |
| txGrant | output | 1 | Local transmit may proceed |
| sleepOk | output | 1 | Local side may enter low power |

## Verification
A wrong state shows on `srdy` in the very next cycle. Examples are a missed request edge, a release taken while the UART is busy, or a deadlock gap of the wrong length. `txGrant` and `sleepOk` follow it combinationally. Off-by-one errors in the stall or gap timers appear only at the end of a timeout window, 16 or 4 clocks after the stall begins. For that reason the bench measures whole high and low runs of `srdy`. It also compares every output against a behavioural model on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/uws_pkg.sv
package uws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } uwsState_e;

  typedef struct packed {
    logic stallInc;
    logic stallClr;
    logic gapInc;
    logic gapClr;
  } uwsStrobe_t;
endpackage

// File: rtl/uws_datapath.sv
module uws_datapath
  import uws_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 16,
  parameter int GAP_CYCLES   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mrdyAsync,
  input  uwsStrobe_t strobe,
  output logic       mrdySync,
  output logic       mrdyRise,
  output logic       stallDone,
  output logic       gapDone
);
  localparam int StallW = $clog2(STALL_CYCLES + 1);
  localparam int GapW   = $clog2(GAP_CYCLES + 1);
  localparam logic [StallW-1:0] StallLast = StallW'(STALL_CYCLES - 1);
  localparam logic [GapW-1:0]   GapLast   = GapW'(GAP_CYCLES - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic [StallW-1:0]    stallCnt;
  logic [GapW-1:0]      gapCnt;

  // synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-1:0], mrdyAsync};
  end

  assign mrdySync = syncQ[SYNC_STAGES-1];
  assign mrdyRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  assign stallDone = strobe.stallInc && (stallCnt == StallLast);
  assign gapDone   = strobe.gapInc && (gapCnt == GapLast);

  always_ff @(posedge clk) begin
    if (rst || strobe.stallClr || stallDone) stallCnt <= '0;
    else if (strobe.stallInc)                stallCnt <= stallCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.gapClr || gapDone) gapCnt <= '0;
    else if (strobe.gapInc)              gapCnt <= gapCnt + 1'b1;
  end

  // R6: the gap timer only completes after being advanced on the previous cycle
  assert_gap_progress_R6: assert property (@(posedge clk) disable iff (rst)
    gapDone && (GAP_CYCLES > 1) |-> $past(strobe.gapInc));

  // R5: the stall timer never completes unless the controller is advancing it
  assert_stall_gated_R5: assert property (@(posedge clk) disable iff (rst)
    stallDone |-> !strobe.stallClr);
endmodule

// File: rtl/uws_control.sv
module uws_control
  import uws_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mrdySync,
  input  logic       mrdyRise,
  input  logic       dataPending,
  input  logic       uartBusy,
  input  logic       stallDone,
  input  logic       gapDone,
  output uwsStrobe_t strobe,
  output logic       srdy,
  output logic       txGrant,
  output logic       sleepOk
);
  uwsState_e state, stateNext;
  logic releaseOk;

  assign releaseOk = !mrdySync && !uartBusy && !dataPending;

  always_comb begin
    strobe    = '{stallInc: 1'b0, stallClr: 1'b1, gapInc: 1'b0, gapClr: 1'b1};
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (mrdyRise || dataPending) stateNext = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (dataPending && !mrdySync) begin
          strobe.stallInc = 1'b1;
          strobe.stallClr = 1'b0;
        end
        if (stallDone)      stateNext = ST_GAP;
        else if (releaseOk) stateNext = ST_IDLE;
      end
      ST_GAP: begin
        strobe.gapInc = 1'b1;
        strobe.gapClr = 1'b0;
        if (gapDone) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign srdy    = (state == ST_ACTIVE);
  assign txGrant = srdy && mrdySync;
  assign sleepOk = (state == ST_IDLE) && releaseOk;

  // R1: a new request edge while idle raises the ready line on the next edge
  assert_wake_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && mrdyRise |=> srdy);

  // R3: a release not caused by the deadlock timer needs peer low, UART idle, nothing pending
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(srdy) && !$past(stallDone) |-> $past(!mrdySync && !uartBusy && !dataPending));

  // R6: leaving the gap only happens when the gap timer completes
  assert_gap_exit_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(srdy) && $past(state == ST_GAP) |-> $past(gapDone));
endmodule

// File: rtl/uart_wake_slave.sv
module uart_wake_slave
  import uws_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 16,
  parameter int GAP_CYCLES   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mrdyAsync,
  input  logic dataPending,
  input  logic uartBusy,
  output logic srdy,
  output logic txGrant,
  output logic sleepOk
);
  uwsStrobe_t strobe;
  logic mrdySync, mrdyRise, stallDone, gapDone;

  uws_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .STALL_CYCLES(STALL_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .mrdyAsync(mrdyAsync),
    .strobe   (strobe),
    .mrdySync (mrdySync),
    .mrdyRise (mrdyRise),
    .stallDone(stallDone),
    .gapDone  (gapDone)
  );

  uws_control u_control (
    .clk        (clk),
    .rst        (rst),
    .mrdySync   (mrdySync),
    .mrdyRise   (mrdyRise),
    .dataPending(dataPending),
    .uartBusy   (uartBusy),
    .stallDone  (stallDone),
    .gapDone    (gapDone),
    .strobe     (strobe),
    .srdy       (srdy),
    .txGrant    (txGrant),
    .sleepOk    (sleepOk)
  );

  // R4: sleep permission and the ready line are never high together
  assert_sleep_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    sleepOk |-> !srdy && !txGrant);

  // R9: a busy UART keeps the ready line from falling
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    srdy && uartBusy && !stallDone |=> srdy);
endmodule

// File: tb/uart_wake_slave_tb.sv
module uart_wake_slave_tb;
  localparam int STALL = 16;
  localparam int GAP   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mrdyAsync = 1'b0, dataPending = 1'b0, uartBusy = 1'b0;
  logic srdy, txGrant, sleepOk;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  bit modelOn = 1'b0;

  always #4 clk = ~clk;

  uart_wake_slave #(.SYNC_STAGES(2), .STALL_CYCLES(STALL), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .mrdyAsync(mrdyAsync), .dataPending(dataPending),
    .uartBusy(uartBusy), .srdy(srdy), .txGrant(txGrant), .sleepOk(sleepOk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: request delay line, mode (0 idle, 1 ready, 2 gap), timers
  bit reqLine[$] = '{0, 0, 0};
  int mode = 0, stallRun = 0, gapRun = 0;

  always @(posedge clk) begin
    bit seen, seenOld, rise;
    int nMode;
    seen = reqLine[1];
    seenOld = reqLine[2];
    rise = seen && !seenOld;
    nMode = mode;
    if (rst) begin
      reqLine = '{0, 0, 0};
      mode = 0; stallRun = 0; gapRun = 0;
    end else begin
      if (mode == 0) begin
        stallRun = 0; gapRun = 0;
        if (rise || dataPending) nMode = 1;
      end else if (mode == 1) begin
        gapRun = 0;
        if (dataPending && !seen) begin
          if (stallRun == STALL - 1) begin nMode = 2; stallRun = 0; end
          else stallRun++;
        end else begin
          stallRun = 0;
          if (!seen && !uartBusy && !dataPending) nMode = 0;
        end
      end else begin
        stallRun = 0;
        if (gapRun == GAP - 1) begin nMode = 1; gapRun = 0; end
        else gapRun++;
      end
      mode = nMode;
      void'(reqLine.pop_back());
      reqLine.push_front(mrdyAsync);
    end
  end

  always @(negedge clk) begin
    if (modelOn && !rst) begin
      bit eSrdy, eGrant, eSleep;
      eSrdy  = (mode == 1);
      eGrant = eSrdy && reqLine[1];
      eSleep = (mode == 0) && !reqLine[1] && !uartBusy && !dataPending;
      check(srdy == eSrdy, "R3 model srdy", srdy, eSrdy);
      check(txGrant == eGrant, "R7 model txGrant", txGrant, eGrant);
      check(sleepOk == eSleep, "R4 model sleepOk", sleepOk, eSleep);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hiRun, loRun;
    cyc(3);
    rst = 1'b0;
    modelOn = 1'b1;
    @(negedge clk);
    // R8: reset state with idle inputs
    check(srdy == 1'b0, "R8 srdy after reset", srdy, 0);
    check(txGrant == 1'b0, "R8 txGrant after reset", txGrant, 0);
    check(sleepOk == 1'b1, "R8 sleepOk after reset", sleepOk, 1);

    // R1: request edge latency
    mrdyAsync = 1'b1;
    cyc(2);
    check(srdy == 1'b0, "R1 srdy before sync", srdy, 0);
    cyc(1);
    check(srdy == 1'b1, "R1 srdy three edges after request", srdy, 1);
    check(txGrant == 1'b1, "R7 grant with both high", txGrant, 1);
    cyc(3);
    // R9: busy holds the line
    mrdyAsync = 1'b0; uartBusy = 1'b1;
    cyc(6);
    check(srdy == 1'b1, "R9 srdy held while busy", srdy, 1);
    check(sleepOk == 1'b0, "R9 no sleep while busy", sleepOk, 0);
    check(txGrant == 1'b0, "R7 grant drops with request", txGrant, 0);
    // R3: release when all clear
    uartBusy = 1'b0;
    cyc(1);
    check(srdy == 1'b0, "R3 release after idle", srdy, 0);
    check(sleepOk == 1'b1, "R4 sleep after release", sleepOk, 1);
    cyc(4);

    // R2: own data raises ready, grant waits for peer
    dataPending = 1'b1;
    cyc(1);
    check(srdy == 1'b1, "R2 srdy on own data", srdy, 1);
    check(txGrant == 1'b0, "R2 grant held off", txGrant, 0);
    mrdyAsync = 1'b1;
    cyc(2);
    check(txGrant == 1'b1, "R2 grant after peer answers", txGrant, 1);
    dataPending = 1'b0; mrdyAsync = 1'b0;
    cyc(4);
    check(srdy == 1'b0, "R3 release after session", srdy, 0);

    // R5/R6: deadlock toggle
    dataPending = 1'b1;
    cyc(1);
    hiRun = 0;
    while (srdy && hiRun < 100) begin hiRun++; cyc(1); end
    check(hiRun == STALL, "R5 stall window length", hiRun, STALL);
    loRun = 0;
    while (!srdy && loRun < 100) begin
      check(sleepOk == 1'b0, "R6 no sleep during gap", sleepOk, 0);
      loRun++; cyc(1);
    end
    check(loRun == GAP, "R6 gap length", loRun, GAP);
    check(srdy == 1'b1, "R6 reassert after gap", srdy, 1);
    dataPending = 1'b0;
    cyc(3);

    // mixed stimulus, checked by the reference model every clock
    for (int i = 0; i < 600; i++) begin
      mrdyAsync   = ($urandom_range(0, 7) < 3);
      dataPending = ($urandom_range(0, 9) == 0) ? ~dataPending : dataPending;
      uartBusy    = ($urandom_range(0, 5) == 0);
      if (i % 150 > 100) mrdyAsync = 1'b0;
      cyc(1);
    end

    // R8: reset mid-session
    dataPending = 1'b1; cyc(5);
    rst = 1'b1; cyc(1);
    check(srdy == 1'b0, "R8 srdy cleared by reset", srdy, 0);
    dataPending = 1'b0; mrdyAsync = 1'b0; uartBusy = 1'b0;
    cyc(2); rst = 1'b0; cyc(1);
    check(sleepOk == 1'b1, "R8 sleep after second reset", sleepOk, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule